// File: doc/BRIEF.md
# CPU bus memory map decoder

This block sits on an 8-bit processor bus with a 16-bit address and a single read/not-write strobe. It decodes every access into one of three regions. The low 8 KB window reaches a 2 KB working RAM that repeats four times across the window. The upper 32 KB is a read-only program store. Everything between the two is left unmapped. The data bus is bidirectional. The block drives it only when the processor reads a mapped location, and releases it to high impedance in every other case.

The program store has no file behind it. Its contents come from an arithmetic function of the address, so the same values can be produced in any flow. Writes into the program store are accepted on the bus and then discarded. The block also provides the bus phase clock, which is the inverse of the system clock. RAM writes commit on the falling edge of the system clock, which is the same instant as the rising edge of the phase clock.

Top module: `mem_map_decoder`

## Requirements
- R1: A write to an address in 0x0000–0x07FF followed by a read of the same address returns the written byte.
- R2: For any address A in 0x0000–0x1FFF, the RAM cell used is A[10:0]. A, A+0x0800, A+0x1000 and A+0x1800 (taken within the window) all reach the same byte.
- R3: A read of any address A in 0x8000–0xFFFF drives the bus with A[7:0] XOR {0, A[14:8]}, up to and including 0xFFFF.
- R4: A write to the 0x8000–0xFFFF range changes neither the value later read back from that address nor any RAM cell.
- R5: Addresses 0x2000–0x7FFF are unmapped. The bus drive enable stays low for reads and writes there, and a write there leaves the RAM cell at A[10:0] unchanged.
- R6: The bus drive enable is high only while the read/not-write input is high and the address is mapped. During every write the bus is released.
- R7: A RAM write stores the byte present on the bus at the falling edge of the system clock. A change to the bus after that edge and within the same cycle has no effect.
- R8: The phase clock output is low while the system clock is high, and high while it is low.
- R9: While reset is high, the bus drive enable is low and RAM writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rnw | input | 1 | High for a read, low for a write |
| addr | input | 16 | Processor address |
| data | inout | 8 | Bidirectional data bus |
| data_oe | output | 1 | High while the block drives the data bus |
| phase_clk | output | 1 | Bus phase clock, the inverse of clk |

## Verification
Some properties are checked by assertions on every cycle. The bus is driven only during reads. Unmapped addresses never enable the drivers. Every read of a mapped address enables them. An access to the program store never raises the RAM write strobe. The bench's sweeps cover what only stored contents can show. These are the four-way RAM mirroring, the full program store value map up to 0xFFFF, the fact that writes to the program store and to unmapped space leave memory intact, the falling-edge capture point, and the suppression of writes under reset.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int RAM_AW   = 11;   // 2 KB working store
    localparam int WIN_AW   = 13;   // low window 0x0000-0x1FFF holds mirrors
    localparam int ROM_AW   = ADDR_W - 1;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_ROM  = 2'd2
    } region_e;

    typedef struct packed {
        region_e region;
        logic    ram_we;
        logic    bus_oe;
    } decode_t;

    // Classify an address into a region.
    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1])
            return RGN_ROM;
        else if (a[ADDR_W-2:WIN_AW] == '0)
            return RGN_RAM;
        else
            return RGN_NONE;
    endfunction

    // Program store content, computed from the byte offset.
    function automatic logic [DATA_W-1:0] rom_byte(input logic [ROM_AW-1:0] off);
        logic [DATA_W-1:0] hi;
        hi = '0;
        hi[ROM_AW-DATA_W-1:0] = off[ROM_AW-1:DATA_W];
        return off[DATA_W-1:0] ^ hi;
    endfunction

endpackage

// File: rtl/mmd_decode.sv
module mmd_decode
    import mmd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          rst,
    input  logic          rnw,
    input  logic [AW-1:0] addr,
    output decode_t       dec
);

    always_comb begin
        dec.region = region_of(addr);
        dec.bus_oe = !rst && rnw && (dec.region != RGN_NONE);
        dec.ram_we = !rst && !rnw && (dec.region == RGN_RAM);
    end

endmodule

// File: rtl/mmd_ram.sv
module mmd_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Commit on the falling system edge (rising phase edge).
    always_ff @(negedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/mmd_rom.sv
module mmd_rom
    import mmd_pkg::*;
#(
    parameter int AW = ROM_AW,
    parameter int DW = DATA_W
) (
    input  logic [AW-1:0] off,
    output logic [DW-1:0] rdata
);

    always_comb rdata = rom_byte(off);

endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
    import mmd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int RW = RAM_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rnw,
    input  logic [AW-1:0] addr,
    inout  wire  [DW-1:0] data,
    output logic          data_oe,
    output logic          phase_clk
);

    localparam int OFF_W = AW - 1;

    decode_t        dec;
    logic [DW-1:0]  ram_q;
    logic [DW-1:0]  rom_q;
    logic [DW-1:0]  rd_mux;

    assign phase_clk = ~clk;

    mmd_decode #(.AW(AW)) u_dec (
        .rst  (rst),
        .rnw  (rnw),
        .addr (addr),
        .dec  (dec)
    );

    mmd_ram #(.AW(RW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (dec.ram_we),
        .idx   (addr[RW-1:0]),
        .wdata (data),
        .rdata (ram_q)
    );

    mmd_rom #(.AW(OFF_W), .DW(DW)) u_rom (
        .off   (addr[OFF_W-1:0]),
        .rdata (rom_q)
    );

    always_comb rd_mux = (dec.region == RGN_ROM) ? rom_q : ram_q;

    assign data_oe = dec.bus_oe;
    assign data    = data_oe ? rd_mux : {DW{1'bz}};

    AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> rnw); // R6

    AST_UNMAPPED_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (!addr[AW-1] && addr[AW-2:WIN_AW] != '0) |-> !data_oe); // R5

    AST_MAPPED_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        (rnw && (addr[AW-1] || addr[AW-2:WIN_AW] == '0)) |-> data_oe); // R3

    AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        addr[AW-1] |-> !dec.ram_we); // R4

endmodule

// File: tb/tb_mem_map_decoder.sv
`timescale 1ns/1ps
module tb_mem_map_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rnw = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_val = 8'h00;
    wire  [7:0]  bus;
    logic        data_oe;
    logic        phase_clk;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 0;

    assign bus = tb_drv ? tb_val : 8'hzz;

    always #5 clk = ~clk;

    mem_map_decoder dut (
        .clk       (clk),
        .rst       (rst),
        .rnw       (rnw),
        .addr      (addr),
        .data      (bus),
        .data_oe   (data_oe),
        .phase_clk (phase_clk)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h (addr=%h)", req, act, exp, addr);
        end
    endtask

    function automatic logic [7:0] rom_exp(input logic [15:0] a);
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    function automatic logic [7:0] pat(input int i, input int salt);
        return 8'((i * 7 + salt) & 8'hFF);
    endfunction

    // Inputs change 1 ns after the rising edge; the write commits at the falling edge.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d, output logic oe);
        @(posedge clk); #1;
        addr = a; rnw = 1'b0; tb_val = d; tb_drv = 1'b1;
        #6 oe = data_oe;
        @(posedge clk); #1;
        tb_drv = 1'b0; rnw = 1'b1;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        @(posedge clk); #1;
        addr = a; rnw = 1'b1; tb_drv = 1'b0;
        #6;
        d = bus; oe = data_oe;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       oe;

        // R9: reset holds drivers off
        repeat (3) @(posedge clk);
        #1 addr = 16'h0005; rnw = 1'b1;
        #3 check("R9 oe in reset", 16'(data_oe), 16'h0);
        @(posedge clk); #1 rst = 1'b0;

        // R8: phase clock polarity
        @(posedge clk); #2 check("R8 phase while clk high", 16'(phase_clk), 16'h0);
        #5 check("R8 phase while clk low", 16'(phase_clk), 16'h1);

        // R9: writes suppressed in reset
        do_write(16'h0005, 8'h11, oe);
        @(posedge clk); #1 rst = 1'b1;
        do_write(16'h0005, 8'h99, oe);
        do_read(16'h8000, d, oe);
        check("R9 no drive on ROM read in reset", 16'(oe), 16'h0);
        @(posedge clk); #1 rst = 1'b0;
        do_read(16'h0005, d, oe);
        check("R9 write ignored in reset", 16'(d), 16'h11);

        // R1 / R6: fill RAM through the base image
        for (int i = 0; i < 2048; i++) begin
            do_write(16'(i), pat(i, 3), oe);
            check("R6 oe low on RAM write", 16'(oe), 16'h0);
        end
        for (int i = 0; i < 2048; i++) begin
            do_read(16'(i), d, oe);
            check("R1 RAM readback", 16'(d), 16'(pat(i, 3)));
            check("R6 oe on RAM read", 16'(oe), 16'h1);
        end

        // R2: all four images, writes through one mirror seen in the others
        for (int i = 0; i < 2048; i += 37) begin
            do_write(16'h1800 + 16'(i), pat(i, 91), oe);
            for (int m = 0; m < 4; m++) begin
                do_read(16'(m * 16'h0800 + i), d, oe);
                check("R2 mirror image", 16'(d), 16'(pat(i, 91)));
            end
        end

        // R3: full program store sweep
        for (int a = 16'h8000; a <= 16'hFFFF; a++) begin
            do_read(16'(a), d, oe);
            check("R3 ROM value", 16'(d), 16'(rom_exp(16'(a))));
            if (oe !== 1'b1) check("R3 ROM drive", 16'(oe), 16'h1);
        end

        // R4: writes into program store discarded
        for (int a = 16'h8000; a <= 16'hFFFF; a += 16'h0BCD) begin
            do_write(16'(a), 8'hA5, oe);
            check("R6 oe low on ROM write", 16'(oe), 16'h0);
            do_read(16'(a), d, oe);
            check("R4 ROM unchanged", 16'(d), 16'(rom_exp(16'(a))));
            do_read(16'(a) & 16'h07FF, d, oe);
            check("R4 RAM untouched by ROM write", 16'(d),
                  16'((((a & 16'h07FF) % 37) == 0) ? pat(a & 16'h07FF, 91) : pat(a & 16'h07FF, 3)));
        end
        do_write(16'hFFFF, 8'h00, oe);
        do_read(16'hFFFF, d, oe);
        check("R4 top address unchanged", 16'(d), 16'(rom_exp(16'hFFFF)));

        // R5: unmapped space floats and leaves RAM unchanged
        for (int a = 16'h2000; a < 16'h8000; a += 16'h0123) begin
            do_read(16'(a), d, oe);
            check("R5 unmapped read float", 16'(oe), 16'h0);
            do_write(16'(a), 8'h5A, oe);
            check("R5 unmapped write float", 16'(oe), 16'h0);
            do_read(16'(a) & 16'h07FF, d, oe);
            check("R5 RAM untouched", 16'(d),
                  16'((((a & 16'h07FF) % 37) == 0) ? pat(a & 16'h07FF, 91) : pat(a & 16'h07FF, 3)));
        end
        do_read(16'h4000, d, oe);
        check("R5 0x4000 float", 16'(oe), 16'h0);

        // R7: data sampled at falling edge, later change ignored
        @(posedge clk); #1;
        addr = 16'h0123; rnw = 1'b0; tb_val = 8'h3C; tb_drv = 1'b1;
        @(negedge clk); #1 tb_val = 8'hC3;
        @(posedge clk); #1 tb_drv = 1'b0; rnw = 1'b1;
        do_read(16'h0123, d, oe);
        check("R7 falling-edge capture", 16'(d), 16'h3C);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule